// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block produces one pulse-width-modulated output for a display backlight, together with a separate on/off pin for the backlight supply. A host programs it through a byte-wide register port. A control register holds a run flag and a 7-bit divider code. A level register sets the on-time. A third register drives the backlight-enable pin directly.

A prescaler divides the block clock by the divider code plus one. Each divided tick advances an 8-bit period counter, so a period always lasts 256 ticks. The output is high at the start of each period and stays high while the counter is below the active level. The level is sampled only at a period boundary, or continuously while the generator is stopped. A level written mid-period therefore never truncates or stretches the current pulse.

The register port is plain control access with no stream data. Every access is accepted in the cycle it is presented, and there is no back-pressure. Read data is registered and appears the cycle after the read strobe.

Top module: `bklt_pwm`

## Requirements
- R1: A synchronous active-high reset clears all three registers, so `rdata` reads 0x00 from each of them, and `pwm_out` and `bl_en` are low.
- R2: The control register sits at 0x4B, with bit 7 as the run flag and bits 6:0 as the divider code. The level register sits at 0x4E. The backlight register sits at 0x51 and keeps bit 0 only. A write with `wr_en` takes effect at the clock edge. A read with `rd_en` returns the stored value on `rdata` after that edge.
- R3: A read of any other address returns 0x00. A write to any other address changes no register.
- R4: `bl_en` equals bit 0 of the backlight register. It does not depend on the run flag or the PWM state.
- R5: While the run flag is 0, `pwm_out` is low and the prescaler and period counter are held at zero. In the first cycle after the flag is set, a period begins from count zero.
- R6: Divider code N makes the period counter advance once every N+1 clocks. A period therefore lasts 256*(N+1) clocks: code 0x00 gives no division, 0x63 divides by 100 and 0x7F divides by 128.
- R7: With active level L from 1 to 254, `pwm_out` is high for the first L*(N+1) clocks of each period and low for the rest.
- R8: Level 0xFF holds `pwm_out` high for the whole period. Level 0x00 holds it low for the whole period.
- R9: A level written while running takes effect at the next period boundary. The current period completes with the old level.
- R10: In the driver sequence of clearing the control register and then writing a new divider code with the run flag set, `pwm_out` is low while the register is clear. The first period under the new code is complete and correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler base |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pwm_out | output | 1 | PWM output, active high |
| bl_en | output | 1 | Backlight supply enable |

## Verification
The generator is measured as high-clock counts over windows that are exactly one period long and start on the enable edge. A wrong period length or a start that is off by one shows up as a miscount. Levels 0x40 and 0x80 at divider codes 0, 3 and 0x7F separate a correct prescale ratio from an off-by-one ratio, because the high count scales with N+1. The extremes 0x00 and 0xFF show whether the compare is strict and whether full scale is handled as a special case. A level rewritten early in a period, measured across two consecutive periods, shows whether the level is latched at the boundary or applied at once. The clear-then-reload sequence, together with reads of unmapped addresses and a backlight toggle while stopped, covers register isolation.

// File: rtl/bklt_pkg.sv
package bklt_pkg;
  localparam int AW      = 8;
  localparam int DW      = 8;
  localparam int DIV_W   = 7;
  localparam int CNT_W   = 8;

  localparam logic [AW-1:0] ADDR_CTL = 8'h4B;
  localparam logic [AW-1:0] ADDR_LVL = 8'h4E;
  localparam logic [AW-1:0] ADDR_BL  = 8'h51;

  typedef struct packed {
    logic             run;
    logic [DIV_W-1:0] div;
  } ctl_t;
endpackage

// File: rtl/bklt_regs.sv
module bklt_regs
  import bklt_pkg::*;
#(
  parameter logic [AW-1:0] A_CTL = ADDR_CTL,
  parameter logic [AW-1:0] A_LVL = ADDR_LVL,
  parameter logic [AW-1:0] A_BL  = ADDR_BL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output ctl_t          ctl_q,
  output logic [DW-1:0] lvl_q,
  output logic          bl_q,
  output logic [DW-1:0] rdata
);
  logic hit_ctl, hit_lvl, hit_bl;
  logic [DW-1:0] rd_mux;

  assign hit_ctl = (addr == A_CTL);
  assign hit_lvl = (addr == A_LVL);
  assign hit_bl  = (addr == A_BL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      lvl_q <= '0;
      bl_q  <= 1'b0;
    end else if (wr_en) begin
      if (hit_ctl) ctl_q <= ctl_t'(wdata);
      if (hit_lvl) lvl_q <= wdata;
      if (hit_bl)  bl_q  <= wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctl)      rd_mux = DW'(ctl_q);
    else if (hit_lvl) rd_mux = lvl_q;
    else if (hit_bl)  rd_mux = {{(DW-1){1'b0}}, bl_q};
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/bklt_prescale.sv
module bklt_prescale #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [DIV_W-1:0] pre_cnt
);
  logic at_end;
  assign at_end = (pre_cnt == div);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run)  pre_cnt <= '0;
    else if (at_end)  pre_cnt <= '0;
    else              pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/bklt_frame.sv
module bklt_frame #(
  parameter int CNT_W     = 8,
  parameter bit FULL_HOLD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] lvl_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_lvl,
  output logic             wrap,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic on;

  assign wrap = tick && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_lvl <= '0;
    end else if (!run) begin
      cnt     <= '0;
      act_lvl <= lvl_in;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      if (wrap) act_lvl <= lvl_in;
    end
  end

  generate
    if (FULL_HOLD) begin : g_full
      assign on = (act_lvl == CNT_MAX) || (cnt < act_lvl);
    end else begin : g_plain
      assign on = (cnt < act_lvl);
    end
  endgenerate

  assign pwm = run && on;
endmodule

// File: rtl/bklt_pwm.sv
module bklt_pwm
  import bklt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pwm_out,
  output logic          bl_en
);
  ctl_t             ctl_q;
  logic [DW-1:0]    lvl_q;
  logic             bl_q;
  logic             run;
  logic             tick;
  logic [DIV_W-1:0] pre_cnt;
  logic [CNT_W-1:0] frame_cnt;
  logic [CNT_W-1:0] act_lvl;
  logic             wrap;

  bklt_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata),
    .ctl_q(ctl_q), .lvl_q(lvl_q), .bl_q(bl_q), .rdata(rdata)
  );

  assign run = ctl_q.run;

  bklt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .div(ctl_q.div),
    .tick(tick), .pre_cnt(pre_cnt)
  );

  bklt_frame #(.CNT_W(CNT_W), .FULL_HOLD(1'b1)) u_frame (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .lvl_in(lvl_q),
    .cnt(frame_cnt), .act_lvl(act_lvl), .wrap(wrap), .pwm(pwm_out)
  );

  assign bl_en = bl_q;
endmodule

// File: rtl/bklt_pwm_chk.sv
module bklt_pwm_chk
  import bklt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic             wbit0,
  input logic [DW-1:0]    rdata,
  input logic             bl_en,
  input logic             pwm_out,
  input logic             run,
  input logic             tick,
  input logic [DIV_W-1:0] pre_cnt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_lvl,
  input logic             wrap
);
  logic unmapped;
  assign unmapped = (addr != ADDR_CTL) && (addr != ADDR_LVL) && (addr != ADDR_BL);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pre_cnt == '0) && (cnt == '0)); // R5

  AST_LVL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(act_lvl)); // R9

  AST_CNT_WAITS_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt)); // R6

  AST_BL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_BL) |=> (bl_en == $past(wbit0))); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && unmapped) |=> (rdata == '0)); // R3

  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (run && act_lvl == '1) |-> pwm_out); // R8
endmodule

bind bklt_pwm bklt_pwm_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wbit0(wdata[0]), .rdata(rdata), .bl_en(bl_en), .pwm_out(pwm_out),
  .run(run), .tick(tick), .pre_cnt(pre_cnt), .cnt(frame_cnt),
  .act_lvl(act_lvl), .wrap(wrap)
);

// File: tb/sim_bklt_pwm.sv
module sim_bklt_pwm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwm_out;
  logic       bl_en;

  bklt_pwm u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .bl_en(bl_en)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    hi;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   meas_on = 1'b0;
  int   frame_len = 256;
  int   hi_cnt = 0;
  int   cyc_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    @(posedge clk); #2;
    rd_en = 1'b1; addr = a;
    @(posedge clk); #2;
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic push_exp(input int hi, input string tag);
    exp_t e;
    e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // call right after the enabling write: first frame cycle is sampled next negedge
  task automatic arm(input int len);
    frame_len = len; hi_cnt = 0; cyc_cnt = 0; meas_on = 1'b1;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    meas_on = 1'b0;
    @(posedge clk); #2;
  endtask

  // monitor: per-frame high count against the scoreboard
  always @(negedge clk) begin
    if (meas_on) begin
      if (pwm_out) hi_cnt++;
      cyc_cnt++;
      if (cyc_cnt == frame_len) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(hi_cnt == e.hi, e.tag, hi_cnt, e.hi);
        end
        hi_cnt = 0; cyc_cnt = 0;
      end
    end
  end

  task automatic run_cfg(input logic [6:0] dv, input logic [7:0] lv,
                         input int frames, input int hi, input string tag);
    reg_wr(8'h4B, 8'h00);
    reg_wr(8'h4E, lv);
    reg_wr(8'h4B, {1'b1, dv});
    arm(256 * (int'(dv) + 1));
    for (int i = 0; i < frames; i++) push_exp(hi, tag);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int lows;
    repeat (3) @(posedge clk); #2;
    rst = 1'b0;

    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm_out after reset", pwm_out, 0);
    check(bl_en == 1'b0, "R1 bl_en after reset", bl_en, 0);
    reg_rd(8'h4B, d); check(d == 8'h00, "R1 ctl reset", d, 0);
    reg_rd(8'h4E, d); check(d == 8'h00, "R1 lvl reset", d, 0);
    reg_rd(8'h51, d); check(d == 8'h00, "R1 bl reset", d, 0);

    // R2 readback
    reg_wr(8'h4E, 8'hA5); reg_rd(8'h4E, d); check(d == 8'hA5, "R2 lvl readback", d, 8'hA5);
    reg_wr(8'h4B, 8'h63); reg_rd(8'h4B, d); check(d == 8'h63, "R2 ctl readback", d, 8'h63);

    // R3 unmapped write ignored, read zero
    reg_wr(8'h4C, 8'hFF);
    reg_wr(8'h00, 8'h81);
    reg_rd(8'h4C, d); check(d == 8'h00, "R3 unmapped read", d, 0);
    reg_rd(8'h4B, d); check(d == 8'h63, "R3 ctl untouched", d, 8'h63);
    reg_rd(8'h4E, d); check(d == 8'hA5, "R3 lvl untouched", d, 8'hA5);
    check(pwm_out == 1'b0, "R3 no run from stray write", pwm_out, 0);

    // R4 backlight pin independent of PWM
    reg_wr(8'h51, 8'h01);
    check(bl_en == 1'b1, "R4 bl_en set while stopped", bl_en, 1);
    reg_rd(8'h51, d); check(d == 8'h01, "R2 bl readback", d, 1);

    // R5 stopped: output low regardless of level
    lows = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!pwm_out) lows++; end
    check(lows == 300, "R5 low while stopped", lows, 300);

    // R6 R7 frame measurements
    run_cfg(7'h00, 8'h40, 2, 64, "R7 div0 lvl40");
    run_cfg(7'h03, 8'h80, 2, 512, "R6 div3 lvl80");
    run_cfg(7'h7F, 8'h01, 1, 128, "R6 div7F lvl01");
    // R8 extremes
    run_cfg(7'h00, 8'hFF, 2, 256, "R8 full scale");
    run_cfg(7'h00, 8'h00, 2, 0, "R8 zero level");
    check(bl_en == 1'b1, "R4 bl_en held through PWM activity", bl_en, 1);

    // R9 mid-period level change
    reg_wr(8'h4B, 8'h00);
    reg_wr(8'h4E, 8'h20);
    reg_wr(8'h4B, 8'h81);
    arm(512);
    push_exp(64, "R9 old level kept");
    push_exp(192, "R9 new level next period");
    repeat (5) @(posedge clk);
    reg_wr(8'h4E, 8'h60);
    drain();

    // R10 clear then reload divider while running
    reg_wr(8'h4B, 8'h00);
    @(negedge clk);
    check(pwm_out == 1'b0, "R10 low while cleared", pwm_out, 0);
    reg_wr(8'h4E, 8'h80);
    reg_wr(8'h4B, 8'h82);
    arm(768);
    push_exp(384, "R10 first period new divider");
    push_exp(384, "R10 second period new divider");
    drain();

    // R4 clear backlight
    reg_wr(8'h51, 8'h00);
    check(bl_en == 1'b0, "R4 bl_en cleared while running", bl_en, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule